// File: doc/BRIEF.md
# Nested Call Clock-Enable Controller

This block decides, cycle by cycle, whether the emulated user clocks may advance while calls between the hardware side and the software side nest inside one another. Two directions of call exist. An imported call runs from hardware to software, and the user clocks must stand still until software answers it. An exported call runs from software into hardware, either as a zero-time function or as a time-consuming task. A time-consuming task needs running clocks to do its work. Each start and each return event is pushed onto or popped from a bounded stack of active call contexts. The innermost context, together with any zero-time context still open beneath it, sets the next value of the registered clock-enable.

The block also marks each hardware-to-software message it causes. Accepting an imported call start produces an activation message. Accepting an exported call return produces a return message. A legacy clock-hold input overrides everything else and forces the enable low in the same cycle. Two sticky flags record misuse: one for a push onto a full stack, and one for a malformed start or return.

Top module: `callnest_clk_ctrl`

## Requirements
- R1: After reset the stack is empty, `user_clk_en` is 1 (provided `legacy_hold` is 0), `h2s_msg_valid` is 0 and both error flags are 0.
- R2: Call kinds are 2'b00 imported, 2'b01 exported zero-time and 2'b10 exported time-consuming. An accepted imported start drives `user_clk_en` to 0 from the next cycle, and it stays 0 until that call's return is accepted, unless a deeper context allows running.
- R3: While any exported zero-time context is on the stack, `user_clk_en` is 0, including when a time-consuming task is nested deeper.
- R4: When the innermost context is an exported time-consuming task and no zero-time context is on the stack, `user_clk_en` is 1 from the cycle after the push or pop that made it innermost.
- R5: An imported call nested inside a running time-consuming task stops the clocks in the next cycle, and accepting its return lets them run again in the cycle after.
- R6: While `legacy_hold` is 1, `user_clk_en` is 0 in that same cycle, whatever the stack holds.
- R7: One cycle after an accepted imported start, `h2s_msg_valid` pulses for one cycle with `h2s_msg_tag` = 0 (activation). One cycle after an accepted exported return, it pulses with tag 1 (return). Imported returns, exported starts and rejected events give no message.
- R8: A start with the reserved kind 2'b11 sets `protocol_err` and pushes nothing.
- R9: A start while DEPTH contexts are open sets the sticky `overflow_err` and is ignored.
- R10: A return when the stack is empty, or whose kind differs from the innermost context, sets the sticky `protocol_err` and leaves the stack unchanged.
- R11: When `call_start` and `call_ret` are both 1 in one cycle, only the return is processed and the start is dropped without any error.
- R12: Imported and exported calls may alternate inside each other up to DEPTH levels, and unwinding them in order restores the running state with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_start | input | 1 | A call begins this cycle |
| call_start_kind | input | 2 | Kind of the beginning call |
| call_ret | input | 1 | A call returns this cycle |
| call_ret_kind | input | 2 | Kind of the returning call |
| legacy_hold | input | 1 | External hold that forces the clocks stopped |
| user_clk_en | output | 1 | Enable for the emulated user clocks |
| h2s_msg_valid | output | 1 | One-cycle pulse: a hardware-to-software message is due |
| h2s_msg_tag | output | 1 | 0 = activation of an imported call, 1 = return of an exported call |
| overflow_err | output | 1 | Sticky: push onto a full stack |
| protocol_err | output | 1 | Sticky: bad return or reserved start kind |

## Verification
A stack pointer or a stored kind that has gone wrong shows at the ports one cycle after the next pop. The enable takes the value of the wrong context, or a correct return is refused and `protocol_err` rises. A miscounted set of zero-time contexts lets the clocks run inside a zero-time function. This shows in the very cycle after the time-consuming task is pushed. The directed scenarios therefore unwind every stack they build, so that each stored entry is read back through a return.

// File: rtl/callnest_pkg.sv
package callnest_pkg;

  typedef enum logic [1:0] {
    K_IMPORT = 2'b00,
    K_EXP_ZT = 2'b01,
    K_EXP_TC = 2'b10,
    K_RSVD   = 2'b11
  } call_kind_e;

  localparam logic TAG_ACTIVATE = 1'b0;
  localparam logic TAG_RETURN   = 1'b1;

  function automatic logic kind_ok(input logic [1:0] k);
    return k != K_RSVD;
  endfunction

  function automatic logic kind_is_export(input logic [1:0] k);
    return (k == K_EXP_ZT) || (k == K_EXP_TC);
  endfunction

  // Clocks may run with nothing open, or when a time-consuming task is
  // innermost and no zero-time context encloses it.
  function automatic logic clocks_may_run(input logic       empty,
                                          input logic [1:0] top,
                                          input logic       zt_open);
    if (empty) return 1'b1;
    return (top == K_EXP_TC) && !zt_open;
  endfunction

endpackage

// File: rtl/cn_ctx_stack.sv
module cn_ctx_stack
  import callnest_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic [1:0] start_kind,
  input  logic       ret_req,
  input  logic [1:0] ret_kind,
  output logic       push_ok,
  output logic       pop_ok,
  output logic       ovf_hit,
  output logic       proto_hit,
  output logic       full,
  output logic       nxt_empty,
  output logic [1:0] nxt_top,
  output logic       nxt_zt_open
);

  logic [1:0]       ctx_mem [DEPTH];
  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] zt_cnt_q;
  logic [PTR_W-1:0] sp_d;
  logic [PTR_W-1:0] zt_cnt_d;
  logic             empty;
  logic [1:0]       top_kind;
  logic [1:0]       below_kind;
  logic             start_eff;

  assign empty      = (sp_q == '0);
  assign full       = (sp_q == PTR_W'(DEPTH));
  assign top_kind   = empty ? K_IMPORT : ctx_mem[IDX_W'(sp_q - PTR_W'(1))];
  assign below_kind = (sp_q >= PTR_W'(2)) ? ctx_mem[IDX_W'(sp_q - PTR_W'(2))] : K_IMPORT;

  // A return in the same cycle wins over a start.
  assign start_eff = start_req && !ret_req;
  assign pop_ok    = ret_req && !empty && (top_kind == ret_kind);
  assign push_ok   = start_eff && kind_ok(start_kind) && !full;
  assign ovf_hit   = start_eff && kind_ok(start_kind) && full;
  assign proto_hit = (ret_req && !pop_ok) || (start_eff && !kind_ok(start_kind));

  always_comb begin
    sp_d     = sp_q;
    zt_cnt_d = zt_cnt_q;
    nxt_top  = top_kind;
    if (push_ok) begin
      sp_d    = sp_q + PTR_W'(1);
      nxt_top = start_kind;
      if (start_kind == K_EXP_ZT) zt_cnt_d = zt_cnt_q + PTR_W'(1);
    end else if (pop_ok) begin
      sp_d    = sp_q - PTR_W'(1);
      nxt_top = below_kind;
      if (top_kind == K_EXP_ZT) zt_cnt_d = zt_cnt_q - PTR_W'(1);
    end
  end

  assign nxt_empty   = (sp_d == '0);
  assign nxt_zt_open = (zt_cnt_d != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q     <= '0;
      zt_cnt_q <= '0;
    end else begin
      sp_q     <= sp_d;
      zt_cnt_q <= zt_cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctx_mem[g] <= K_IMPORT;
      end else if (push_ok && (sp_q == PTR_W'(g))) begin
        ctx_mem[g] <= start_kind;
      end
    end
  end

endmodule

// File: rtl/cn_clk_gate.sv
module cn_clk_gate
  import callnest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nxt_empty,
  input  logic [1:0] nxt_top,
  input  logic       nxt_zt_open,
  input  logic       legacy_hold,
  output logic       clk_en
);

  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b1;
    else        run_q <= clocks_may_run(nxt_empty, nxt_top, nxt_zt_open);
  end

  // The legacy hold overrides in the same cycle.
  assign clk_en = run_q && !legacy_hold;

endmodule

// File: rtl/cn_msg_tag.sv
module cn_msg_tag
  import callnest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_ok,
  input  logic [1:0] start_kind,
  input  logic       pop_ok,
  input  logic [1:0] ret_kind,
  output logic       msg_valid,
  output logic       msg_tag
);

  logic act_ev;
  logic ret_ev;

  assign act_ev = push_ok && (start_kind == K_IMPORT);
  assign ret_ev = pop_ok && kind_is_export(ret_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_tag   <= TAG_ACTIVATE;
    end else begin
      msg_valid <= act_ev || ret_ev;
      msg_tag   <= ret_ev ? TAG_RETURN : TAG_ACTIVATE;
    end
  end

endmodule

// File: rtl/cn_err_sticky.sv
module cn_err_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_hit,
  input  logic proto_hit,
  output logic overflow_err,
  output logic protocol_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow_err <= 1'b0;
      protocol_err <= 1'b0;
    end else begin
      overflow_err <= overflow_err || ovf_hit;
      protocol_err <= protocol_err || proto_hit;
    end
  end

endmodule

// File: rtl/callnest_clk_ctrl.sv
module callnest_clk_ctrl
  import callnest_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       call_start,
  input  logic [1:0] call_start_kind,
  input  logic       call_ret,
  input  logic [1:0] call_ret_kind,
  input  logic       legacy_hold,
  output logic       user_clk_en,
  output logic       h2s_msg_valid,
  output logic       h2s_msg_tag,
  output logic       overflow_err,
  output logic       protocol_err
);

  // Named internal events, also observed by the bound checker.
  logic       push_ok_w;
  logic       pop_ok_w;
  logic       ovf_hit_w;
  logic       proto_hit_w;
  logic       full_w;
  logic       nxt_empty_w;
  logic [1:0] nxt_top_w;
  logic       nxt_zt_open_w;

  cn_ctx_stack #(.DEPTH(DEPTH)) stack_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (call_start),
    .start_kind (call_start_kind),
    .ret_req    (call_ret),
    .ret_kind   (call_ret_kind),
    .push_ok    (push_ok_w),
    .pop_ok     (pop_ok_w),
    .ovf_hit    (ovf_hit_w),
    .proto_hit  (proto_hit_w),
    .full       (full_w),
    .nxt_empty  (nxt_empty_w),
    .nxt_top    (nxt_top_w),
    .nxt_zt_open(nxt_zt_open_w)
  );

  cn_clk_gate gate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .nxt_empty  (nxt_empty_w),
    .nxt_top    (nxt_top_w),
    .nxt_zt_open(nxt_zt_open_w),
    .legacy_hold(legacy_hold),
    .clk_en     (user_clk_en)
  );

  cn_msg_tag tag_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_ok   (push_ok_w),
    .start_kind(call_start_kind),
    .pop_ok    (pop_ok_w),
    .ret_kind  (call_ret_kind),
    .msg_valid (h2s_msg_valid),
    .msg_tag   (h2s_msg_tag)
  );

  cn_err_sticky err_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovf_hit     (ovf_hit_w),
    .proto_hit   (proto_hit_w),
    .overflow_err(overflow_err),
    .protocol_err(protocol_err)
  );

endmodule

// File: rtl/callnest_chk.sv
module callnest_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       call_start,
  input logic [1:0] call_start_kind,
  input logic       call_ret,
  input logic       legacy_hold,
  input logic       user_clk_en,
  input logic       h2s_msg_valid,
  input logic       h2s_msg_tag,
  input logic       overflow_err,
  input logic       protocol_err,
  input logic       push_ok,
  input logic       pop_ok,
  input logic       full
);

  a_r6_hold_stops: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_hold |-> !user_clk_en);

  a_r2_import_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && call_start_kind == 2'b00) |=> !user_clk_en);

  a_r7_activation_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && call_start_kind == 2'b00) |=> (h2s_msg_valid && !h2s_msg_tag));

  a_r9_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (call_start && !call_ret && full && call_start_kind != 2'b11) |=> overflow_err);

  a_r10_proto_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (call_ret && !pop_ok) |=> protocol_err);

  a_r10_proto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    protocol_err |=> protocol_err);

  a_r11_return_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (call_start && call_ret) |-> !push_ok);

  a_r12_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_ok && pop_ok));

endmodule

bind callnest_clk_ctrl callnest_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .call_start     (call_start),
  .call_start_kind(call_start_kind),
  .call_ret       (call_ret),
  .legacy_hold    (legacy_hold),
  .user_clk_en    (user_clk_en),
  .h2s_msg_valid  (h2s_msg_valid),
  .h2s_msg_tag    (h2s_msg_tag),
  .overflow_err   (overflow_err),
  .protocol_err   (protocol_err),
  .push_ok        (push_ok_w),
  .pop_ok         (pop_ok_w),
  .full           (full_w)
);

// File: tb/callnest_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module callnest_clk_ctrl_tb_top;

  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       call_start;
  logic [1:0] call_start_kind;
  logic       call_ret;
  logic [1:0] call_ret_kind;
  logic       legacy_hold;
  logic       user_clk_en;
  logic       h2s_msg_valid;
  logic       h2s_msg_tag;
  logic       overflow_err;
  logic       protocol_err;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Bench model of the context stack (kinds 0 import, 1 zero-time, 2 time-consuming).
  int  mstk[$];
  bit  m_ovf;
  bit  m_proto;
  bit  m_mv;
  bit  m_mt;

  always #2 clk = ~clk;

  callnest_clk_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .call_start(call_start), .call_start_kind(call_start_kind),
    .call_ret(call_ret), .call_ret_kind(call_ret_kind),
    .legacy_hold(legacy_hold), .user_clk_en(user_clk_en),
    .h2s_msg_valid(h2s_msg_valid), .h2s_msg_tag(h2s_msg_tag),
    .overflow_err(overflow_err), .protocol_err(protocol_err)
  );

  function automatic bit exp_run();
    bit any_zt = 0;
    foreach (mstk[i]) if (mstk[i] == 1) any_zt = 1;
    if (mstk.size() == 0) return 1;
    return (mstk[mstk.size()-1] == 2) && !any_zt;
  endfunction

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(user_clk_en, exp_run() && !legacy_hold, req, "user_clk_en");
    chk(h2s_msg_valid, m_mv, req, "h2s_msg_valid");
    if (m_mv) chk(h2s_msg_tag, m_mt, req, "h2s_msg_tag");
    chk(overflow_err, m_ovf, req, "overflow_err");
    chk(protocol_err, m_proto, req, "protocol_err");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; call_start = 0; call_ret = 0;
    call_start_kind = 0; call_ret_kind = 0; legacy_hold = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mstk.delete(); m_ovf = 0; m_proto = 0; m_mv = 0; m_mt = 0;
  endtask

  // One cycle of stimulus; results are checked at the following negedge.
  task automatic step(input bit s, input bit [1:0] sk, input bit r, input bit [1:0] rk,
                      input string req);
    call_start = s; call_start_kind = sk; call_ret = r; call_ret_kind = rk;
    m_mv = 0;
    if (r) begin
      if (mstk.size() > 0 && mstk[mstk.size()-1] == int'(rk)) begin
        void'(mstk.pop_back());
        if (rk != 0) begin m_mv = 1; m_mt = 1; end
      end else m_proto = 1;
    end else if (s) begin
      if (sk == 3) m_proto = 1;
      else if (mstk.size() == DEPTH) m_ovf = 1;
      else begin
        mstk.push_back(int'(sk));
        if (sk == 0) begin m_mv = 1; m_mt = 0; end
      end
    end
    @(negedge clk);
    call_start = 0; call_ret = 0;
    check_all(req);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, req);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check_all("R1");
  endtask

  task automatic t_import();
    do_reset();
    step(1, 2'b00, 0, 0, "R2");
    idle("R2");
    idle("R2");
    step(0, 0, 1, 2'b00, "R2");
    idle("R7");
  endtask

  task automatic t_zero_time();
    do_reset();
    step(1, 2'b01, 0, 0, "R3");
    step(1, 2'b00, 0, 0, "R3");
    step(1, 2'b10, 0, 0, "R3");
    idle("R3");
    step(0, 0, 1, 2'b10, "R7");
    step(0, 0, 1, 2'b00, "R3");
    step(0, 0, 1, 2'b01, "R7");
  endtask

  task automatic t_time_consuming();
    do_reset();
    step(1, 2'b00, 0, 0, "R4");
    step(1, 2'b10, 0, 0, "R4");
    step(1, 2'b00, 0, 0, "R5");
    step(1, 2'b10, 0, 0, "R4");
    step(0, 0, 1, 2'b10, "R5");
    step(0, 0, 1, 2'b00, "R5");
    step(0, 0, 1, 2'b10, "R4");
    step(0, 0, 1, 2'b00, "R4");
  endtask

  task automatic t_hold();
    do_reset();
    step(1, 2'b10, 0, 0, "R6");
    legacy_hold = 1;
    #1;
    check_all("R6");
    step(1, 2'b00, 0, 0, "R6");
    step(0, 0, 1, 2'b00, "R6");
    @(negedge clk);
    legacy_hold = 0;
    #1;
    check_all("R6");
    step(0, 0, 1, 2'b10, "R6");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < DEPTH; i++)
      step(1, (i % 2 == 0) ? 2'b00 : 2'b10, 0, 0, "R12");
    step(1, 2'b00, 0, 0, "R9");
    for (int i = DEPTH - 1; i >= 0; i--)
      step(0, 0, 1, (i % 2 == 0) ? 2'b00 : 2'b10, "R12");
    idle("R9");
  endtask

  task automatic t_protocol();
    do_reset();
    step(0, 0, 1, 2'b00, "R10");
    do_reset();
    step(1, 2'b00, 0, 0, "R10");
    step(0, 0, 1, 2'b10, "R10");
    step(0, 0, 1, 2'b00, "R10");
    do_reset();
    step(1, 2'b10, 0, 0, "R8");
    step(1, 2'b11, 0, 0, "R8");
    step(0, 0, 1, 2'b10, "R8");
  endtask

  task automatic t_simultaneous();
    do_reset();
    step(1, 2'b10, 0, 0, "R11");
    step(1, 2'b00, 1, 2'b10, "R11");
    idle("R11");
  endtask

  initial begin
    rst_n = 0; call_start = 0; call_ret = 0;
    call_start_kind = 0; call_ret_kind = 0; legacy_hold = 0;
    t_reset();
    t_import();
    t_zero_time();
    t_time_consuming();
    t_hold();
    t_overflow();
    t_protocol();
    t_simultaneous();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule